// File: doc/BRIEF.md
# Effective Address Generator

This block computes the memory address for each load or store of a small DSP-style datapath. It holds eight 16-bit address registers and eight 16-bit offset registers that are paired by index. Each access carries a 6-bit addressing field. The upper three bits pick the addressing mode and the lower three bits pick the register pair. From these the block produces the access address in the same cycle as the request strobe. At the following clock edge it writes the modified pointer back into the selected address register.

The modes cover post-modification by the paired offset (added or subtracted) and post-modification by one (up or down). They also cover plain register-indirect, indexed access with no pointer change, and pre-decrement. One further code takes the address from a 24-bit extension word that travels with the instruction, keeping only its low 16 bits. The remaining codes in the same mode group are reserved and are flagged as illegal.

Both register banks have their own load port so that pointers and offsets can be initialised. A direction input marks each access as a read or a write, and the block passes it through.

Top module: `ea_agen`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero. With no request active, `acc_valid`, `acc_wr` and `acc_illegal` are low.
- R2: Field bits [5:3] are the mode and bits [2:0] the register index n. Mode 3'b100 gives address Rn and leaves Rn unchanged.
- R3: Mode 3'b000 gives address Rn, then writes Rn − Nn into Rn.
- R4: Mode 3'b001 gives address Rn, then writes Rn + Nn into Rn.
- R5: Mode 3'b010 gives address Rn, then writes Rn − 1. Mode 3'b011 gives address Rn, then writes Rn + 1.
- R6: Mode 3'b101 gives address Rn + Nn and leaves Rn unchanged.
- R7: Mode 3'b111 gives address Rn − 1 and leaves Rn − 1 in Rn.
- R8: Field 6'b110000 gives as address bits [15:0] of the 24-bit `req_ext` and changes no register.
- R9: All pointer arithmetic wraps modulo 2^16.
- R10: Mode 3'b110 with a nonzero index raises `acc_illegal`, keeps `acc_valid` and `acc_wr` low and changes no address register.
- R11: During a valid access `acc_wr` equals `req_wr` (1 = write, 0 = read). Otherwise it is low.
- R12: When an address load and a pointer write-back hit the same Rn in one cycle, the write-back wins. A load to a register that is not written back in that cycle takes effect. The address uses the offset held before any offset load in the same cycle.
- R13: With `req_valid` low, `acc_valid` is low, `acc_addr` is zero and no address register changes except through its load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request strobe |
| req_ea | input | 6 | Addressing field: mode [5:3], register index [2:0] |
| req_wr | input | 1 | Access direction, 1 = write |
| req_ext | input | 24 | Extension word for absolute addressing |
| aload_en | input | 1 | Address register load enable |
| aload_idx | input | 3 | Address register load index |
| aload_data | input | 16 | Address register load value |
| oload_en | input | 1 | Offset register load enable |
| oload_idx | input | 3 | Offset register load index |
| oload_data | input | 16 | Offset register load value |
| acc_valid | output | 1 | Access address is valid this cycle |
| acc_addr | output | 16 | Access address, zero when not valid |
| acc_wr | output | 1 | Direction of the valid access |
| acc_illegal | output | 1 | Reserved addressing field seen |

## Verification
The address, direction and illegal flag are combinational. They are due in the cycle the request is presented. A pointer write-back or a register load appears only in accesses made after the next rising edge. The bench therefore changes inputs at the falling edge and compares the outputs a quarter period later, before the rising edge. It updates its own register model just after that edge. Each access result is checked in its own cycle, and each register change is checked through the address of a later access to the same pair.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        EA_POST_SUB_OFS = 3'b000,
        EA_POST_ADD_OFS = 3'b001,
        EA_POST_DEC     = 3'b010,
        EA_POST_INC     = 3'b011,
        EA_PLAIN        = 3'b100,
        EA_INDEXED      = 3'b101,
        EA_SPECIAL      = 3'b110,
        EA_PRE_DEC      = 3'b111
    } ea_mode_e;

    typedef enum logic [2:0] {
        STEP_NONE    = 3'd0,
        STEP_SUB_OFS = 3'd1,
        STEP_ADD_OFS = 3'd2,
        STEP_DEC_ONE = 3'd3,
        STEP_INC_ONE = 3'd4
    } ea_step_e;

    typedef struct packed {
        ea_step_e step;
        logic     addr_from_step;
        logic     absolute;
        logic     writeback;
        logic     reserved;
    } ea_ctrl_t;

    function automatic ea_ctrl_t ea_decode_f(input ea_mode_e mode, input logic idx_zero);
        ea_ctrl_t c;
        c = '{step: STEP_NONE, addr_from_step: 1'b0, absolute: 1'b0,
              writeback: 1'b0, reserved: 1'b0};
        unique case (mode)
            EA_POST_SUB_OFS: begin c.step = STEP_SUB_OFS; c.writeback = 1'b1; end
            EA_POST_ADD_OFS: begin c.step = STEP_ADD_OFS; c.writeback = 1'b1; end
            EA_POST_DEC:     begin c.step = STEP_DEC_ONE; c.writeback = 1'b1; end
            EA_POST_INC:     begin c.step = STEP_INC_ONE; c.writeback = 1'b1; end
            EA_PLAIN:        c.step = STEP_NONE;
            EA_INDEXED:      begin c.step = STEP_ADD_OFS; c.addr_from_step = 1'b1; end
            EA_SPECIAL: begin
                c.absolute = idx_zero;
                c.reserved = !idx_zero;
            end
            EA_PRE_DEC: begin
                c.step           = STEP_DEC_ONE;
                c.addr_from_step = 1'b1;
                c.writeback      = 1'b1;
            end
            default: c.reserved = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int EA_W = IDX_W + MODE_W
) (
    input  logic [EA_W-1:0]  ea,
    output ea_ctrl_t         ctrl,
    output logic [IDX_W-1:0] idx
);

    ea_mode_e mode;

    always_comb begin
        mode = ea_mode_e'(ea[EA_W-1 -: MODE_W]);
        idx  = ea[IDX_W-1:0];
        ctrl = ea_decode_f(mode, (ea[IDX_W-1:0] == '0));
    end

endmodule

// File: rtl/ea_regbank.sv
module ea_regbank #(
    parameter int W  = 16,
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic [W-1:0]  upd_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] slot_q [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (upd_en && (upd_idx == IW'(i))) begin
                slot_q[i] <= upd_data;
            end else if (ld_en && (ld_idx == IW'(i))) begin
                slot_q[i] <= ld_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int W = 16
) (
    input  ea_ctrl_t     ctrl,
    input  logic [W-1:0] base,
    input  logic [W-1:0] ofs,
    input  logic [W-1:0] abs_val,
    output logic [W-1:0] next_val,
    output logic [W-1:0] addr
);

    always_comb begin
        unique case (ctrl.step)
            STEP_SUB_OFS: next_val = base - ofs;
            STEP_ADD_OFS: next_val = base + ofs;
            STEP_DEC_ONE: next_val = base - W'(1);
            STEP_INC_ONE: next_val = base + W'(1);
            default:      next_val = base;
        endcase

        if (ctrl.absolute) begin
            addr = abs_val;
        end else if (ctrl.addr_from_step) begin
            addr = next_val;
        end else begin
            addr = base;
        end
    end

endmodule

// File: rtl/ea_agen.sv
module ea_agen
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int EXT_W   = 24,
    parameter int NUM_REG = 8,
    localparam int IDX_W  = $clog2(NUM_REG),
    localparam int EA_W   = IDX_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_wr,
    input  logic [EXT_W-1:0]  req_ext,
    input  logic              aload_en,
    input  logic [IDX_W-1:0]  aload_idx,
    input  logic [ADDR_W-1:0] aload_data,
    input  logic              oload_en,
    input  logic [IDX_W-1:0]  oload_idx,
    input  logic [ADDR_W-1:0] oload_data,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_wr,
    output logic              acc_illegal
);

    ea_ctrl_t          ctrl;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] ofs_val;
    logic [ADDR_W-1:0] ptr_next;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] ext_lo;
    logic [EXT_W-ADDR_W-1:0] ext_hi_unused;
    logic              go;
    logic              wb_en;

    assign ext_lo        = req_ext[ADDR_W-1:0];
    assign ext_hi_unused = req_ext[EXT_W-1:ADDR_W];

    ea_decode #(.IDX_W(IDX_W)) u_decode (
        .ea   (req_ea),
        .ctrl (ctrl),
        .idx  (sel_idx)
    );

    assign go    = req_valid && !ctrl.reserved;
    assign wb_en = go && ctrl.writeback;

    ea_regbank #(.W(ADDR_W), .N(NUM_REG)) u_ptr_bank (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (aload_en),
        .ld_idx   (aload_idx),
        .ld_data  (aload_data),
        .upd_en   (wb_en),
        .upd_idx  (sel_idx),
        .upd_data (ptr_next),
        .rd_idx   (sel_idx),
        .rd_data  (ptr_val)
    );

    ea_regbank #(.W(ADDR_W), .N(NUM_REG)) u_ofs_bank (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (oload_en),
        .ld_idx   (oload_idx),
        .ld_data  (oload_data),
        .upd_en   (1'b0),
        .upd_idx  ('0),
        .upd_data ('0),
        .rd_idx   (sel_idx),
        .rd_data  (ofs_val)
    );

    ea_calc #(.W(ADDR_W)) u_calc (
        .ctrl     (ctrl),
        .base     (ptr_val),
        .ofs      (ofs_val),
        .abs_val  (ext_lo),
        .next_val (ptr_next),
        .addr     (calc_addr)
    );

    assign acc_valid   = go;
    assign acc_addr    = go ? calc_addr : '0;
    assign acc_wr      = go && req_wr;
    assign acc_illegal = req_valid && ctrl.reserved;

endmodule

// File: rtl/ea_agen_chk.sv
module ea_agen_chk #(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 24,
    parameter int IDX_W  = 3,
    localparam int EA_W  = IDX_W + 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [EA_W-1:0]   req_ea,
    input logic              req_wr,
    input logic [EXT_W-1:0]  req_ext,
    input logic              aload_en,
    input logic [IDX_W-1:0]  aload_idx,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic              acc_illegal
);

    logic [2:0]       mode;
    logic [IDX_W-1:0] idx;
    assign mode = req_ea[EA_W-1 -: 3];
    assign idx  = req_ea[IDX_W-1:0];

    p_idle_outputs_r13: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!acc_valid && !acc_wr && !acc_illegal));

    p_reserved_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'b110 && idx != '0) |-> acc_illegal);

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        acc_illegal |-> (!acc_valid && !acc_wr));

    p_dir_follow_r11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_wr == req_wr));

    p_abs_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'b110 && idx == '0)
        |-> (acc_valid && acc_addr == req_ext[ADDR_W-1:0]));

    p_postinc_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'b100 && !$past(rst) &&
         $past(req_valid && mode == 3'b011 && acc_valid) && idx == $past(idx))
        |-> (acc_addr == ADDR_W'($past(acc_addr) + ADDR_W'(1))));

    p_predec_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'b100 && !$past(rst) &&
         $past(req_valid && mode == 3'b111 && acc_valid) && idx == $past(idx))
        |-> (acc_addr == $past(acc_addr)));

    p_plain_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'b100 && !$past(rst) &&
         $past(req_valid && mode == 3'b100) && idx == $past(idx) &&
         !$past(aload_en && aload_idx == idx))
        |-> (acc_addr == $past(acc_addr)));

endmodule

bind ea_agen ea_agen_chk #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ea      (req_ea),
    .req_wr      (req_wr),
    .req_ext     (req_ext),
    .aload_en    (aload_en),
    .aload_idx   (aload_idx),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .acc_wr      (acc_wr),
    .acc_illegal (acc_illegal)
);

// File: tb/ea_agen_tb.sv
module ea_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_ea = '0;
    logic        req_wr = 1'b0;
    logic [23:0] req_ext = '0;
    logic        aload_en = 1'b0;
    logic [2:0]  aload_idx = '0;
    logic [15:0] aload_data = '0;
    logic        oload_en = 1'b0;
    logic [2:0]  oload_idx = '0;
    logic [15:0] oload_data = '0;
    logic        acc_valid;
    logic [15:0] acc_addr;
    logic        acc_wr;
    logic        acc_illegal;

    int compared   = 0;
    int mismatched = 0;

    logic [15:0] m_ptr [8];
    logic [15:0] m_ofs [8];

    always #10 clk = ~clk;

    ea_agen dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ea(req_ea), .req_wr(req_wr), .req_ext(req_ext),
        .aload_en(aload_en), .aload_idx(aload_idx), .aload_data(aload_data),
        .oload_en(oload_en), .oload_idx(oload_idx), .oload_data(oload_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_illegal(acc_illegal)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One access cycle: drive at falling edge, compare before rising edge,
    // then advance the reference model after the rising edge.
    task automatic step(input logic v, input logic [5:0] ea, input logic wr,
                        input logic [23:0] ext,
                        input logic ae, input logic [2:0] ai, input logic [15:0] ad,
                        input logic oe, input logic [2:0] oi, input logic [15:0] od,
                        input string force_tag);
        int          md;
        int          k;
        logic [15:0] p;
        logic [15:0] o;
        logic [15:0] e_addr;
        logic [15:0] e_next;
        logic        e_wb;
        logic        e_ok;
        logic        e_bad;
        string       tag;
        @(negedge clk);
        req_valid = v; req_ea = ea; req_wr = wr; req_ext = ext;
        aload_en = ae; aload_idx = ai; aload_data = ad;
        oload_en = oe; oload_idx = oi; oload_data = od;
        md = int'(ea[5:3]);
        k  = int'(ea[2:0]);
        p  = m_ptr[k];
        o  = m_ofs[k];
        e_addr = p; e_next = p; e_wb = 1'b0; e_ok = v; e_bad = 1'b0;
        case (md)
            0: begin e_next = p - o;     e_wb = 1'b1; tag = "R3"; end
            1: begin e_next = p + o;     e_wb = 1'b1; tag = "R4"; end
            2: begin e_next = p - 16'd1; e_wb = 1'b1; tag = "R5"; end
            3: begin e_next = p + 16'd1; e_wb = 1'b1; tag = "R5"; end
            4: tag = "R2";
            5: begin e_addr = p + o; tag = "R6"; end
            6: begin
                if (k == 0) begin e_addr = ext[15:0]; tag = "R8"; end
                else begin e_ok = 1'b0; e_bad = v; tag = "R10"; end
            end
            default: begin e_next = p - 16'd1; e_addr = e_next; e_wb = 1'b1; tag = "R7"; end
        endcase
        if (!v) tag = "R13";
        if (force_tag != "") tag = force_tag;
        if (!e_ok) e_addr = '0;
        #5;
        check(tag, "acc_valid",   {15'd0, acc_valid},   {15'd0, e_ok});
        check(tag, "acc_addr",    acc_addr,             e_addr);
        check(tag, "acc_wr",      {15'd0, acc_wr},      {15'd0, e_ok & wr});
        check(tag, "acc_illegal", {15'd0, acc_illegal}, {15'd0, e_bad});
        @(posedge clk);
        if (ae) m_ptr[ai] = ad;
        if (oe) m_ofs[oi] = od;
        if (v && e_ok && e_wb) m_ptr[k] = e_next;
    endtask

    task automatic access(input logic [5:0] ea, input logic wr, input string tag);
        step(1'b1, ea, wr, 24'h0, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 16'd0, tag);
    endtask

    task automatic load_ptr(input logic [2:0] i, input logic [15:0] d);
        step(1'b0, 6'd0, 1'b0, 24'h0, 1'b1, i, d, 1'b0, 3'd0, 16'd0, "R13");
    endtask

    task automatic load_ofs(input logic [2:0] i, input logic [15:0] d);
        step(1'b0, 6'd0, 1'b0, 24'h0, 1'b0, 3'd0, 16'd0, 1'b1, i, d, "R13");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_ptr[i] = '0; m_ofs[i] = '0; end
        // R1: outputs idle while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "acc_valid in reset", {15'd0, acc_valid}, 16'd0);
        check("R1", "acc_wr in reset", {15'd0, acc_wr}, 16'd0);
        check("R1", "acc_illegal in reset", {15'd0, acc_illegal}, 16'd0);
        rst = 1'b0;
        // R1: all pointers and offsets read back as zero
        for (int i = 0; i < 8; i++) access({3'b100, 3'(i)}, 1'b0, "R1");
        for (int i = 0; i < 8; i++) access({3'b101, 3'(i)}, 1'b0, "R1");
        // initialise both banks
        for (int i = 0; i < 8; i++) load_ofs(3'(i), 16'(3 * i + 2));
        for (int i = 0; i < 8; i++) load_ptr(3'(i), 16'(16'h1000 * i + 5));
        // R2: plain indirect, repeated, no change
        for (int i = 0; i < 8; i++) begin
            access({3'b100, 3'(i)}, 1'b0, "R2");
            access({3'b100, 3'(i)}, 1'b1, "R2");
        end
        // R3..R7 with read-back
        access(6'o02, 1'b0, "R3"); access(6'o02, 1'b0, "R3"); access(6'o42, 1'b0, "R3");
        access(6'o13, 1'b1, "R4"); access(6'o13, 1'b0, "R4"); access(6'o43, 1'b0, "R4");
        access(6'o24, 1'b0, "R5"); access(6'o44, 1'b0, "R5");
        access(6'o35, 1'b1, "R5"); access(6'o35, 1'b0, "R5"); access(6'o45, 1'b0, "R5");
        access(6'o56, 1'b0, "R6"); access(6'o56, 1'b1, "R6"); access(6'o46, 1'b0, "R6");
        access(6'o77, 1'b0, "R7"); access(6'o77, 1'b1, "R7"); access(6'o47, 1'b0, "R7");
        // R8: absolute, upper extension bits dropped, no register change
        step(1'b1, 6'o60, 1'b0, 24'hABCDEF, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 16'd0, "R8");
        step(1'b1, 6'o60, 1'b1, 24'hFF0123, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 16'd0, "R8");
        access(6'o40, 1'b0, "R8");
        // R9: wrap in both directions
        load_ptr(3'd1, 16'hFFFF); load_ofs(3'd1, 16'h0002);
        access(6'o11, 1'b0, "R9"); access(6'o41, 1'b0, "R9");
        load_ptr(3'd0, 16'h0000);
        access(6'o20, 1'b0, "R9"); access(6'o40, 1'b0, "R9");
        load_ptr(3'd0, 16'h0000);
        access(6'o70, 1'b0, "R9"); access(6'o40, 1'b0, "R9");
        load_ptr(3'd1, 16'hFFFE); load_ofs(3'd1, 16'h0005);
        access(6'o51, 1'b0, "R9"); access(6'o01, 1'b0, "R9"); access(6'o41, 1'b0, "R9");
        // R10: reserved codes, with either direction, then read back
        for (int i = 1; i < 8; i++) access({3'b110, 3'(i)}, 1'(i & 1), "R10");
        for (int i = 1; i < 8; i++) access({3'b100, 3'(i)}, 1'b0, "R10");
        // R11: direction pass-through and suppression
        access(6'o43, 1'b1, "R11"); access(6'o43, 1'b0, "R11");
        step(1'b0, 6'o43, 1'b1, 24'h0, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 16'd0, "R11");
        // R12: write-back beats load on the same pointer
        step(1'b1, 6'o32, 1'b0, 24'h0, 1'b1, 3'd2, 16'h7777, 1'b0, 3'd0, 16'd0, "R12");
        access(6'o42, 1'b0, "R12");
        // R12: load takes effect when the access does not write back
        step(1'b1, 6'o43, 1'b0, 24'h0, 1'b1, 3'd3, 16'h4321, 1'b0, 3'd0, 16'd0, "R12");
        access(6'o43, 1'b0, "R12");
        // R12: load to a different pointer during a write-back
        step(1'b1, 6'o34, 1'b0, 24'h0, 1'b1, 3'd5, 16'h2468, 1'b0, 3'd0, 16'd0, "R12");
        access(6'o44, 1'b0, "R12"); access(6'o45, 1'b0, "R12");
        // R12: same-cycle offset load is not seen by that access
        step(1'b1, 6'o54, 1'b0, 24'h0, 1'b0, 3'd0, 16'd0, 1'b1, 3'd4, 16'h0100, "R12");
        access(6'o54, 1'b0, "R12");
        // R13: idle cycles change nothing
        for (int i = 0; i < 4; i++)
            step(1'b0, {3'b011, 3'(i)}, 1'b1, 24'h0, 1'b0, 3'd0, 16'd0, 1'b0, 3'd0, 16'd0, "R13");
        for (int i = 0; i < 4; i++) access({3'b100, 3'(i)}, 1'b0, "R13");
        // mixed traffic; tags follow the mode
        for (int n = 0; n < 600; n++) begin
            step(1'($urandom_range(0, 9) != 0), 6'($urandom), 1'($urandom), 24'($urandom),
                 1'($urandom_range(0, 7) == 0), 3'($urandom), 16'($urandom),
                 1'($urandom_range(0, 5) == 0), 3'($urandom), 16'($urandom), "");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule